// File: doc/BRIEF.md
# USB Device Enumeration State Stepper

This block holds the enumeration level of a USB function and moves it one level per clock toward a target level. The levels form a ladder: attached, powered, default, addressed, configured. Every rung crossed produces exactly one event code on a strobed event output, so the logic downstream sees each intermediate transition and never a jump.

Targets come from bus conditions that have already been decoded: cable plug and unplug, bus reset, enumeration complete and set-configuration. Each condition names a rung. A suspend indication does not move the ladder. It produces a single bus-inactive event. After reset the block rests in an init level until a create pulse places it on the attached rung.

Top module: `usb_dev_state_stepper`

## Requirements
- R1: While synchronous active-low reset is applied, and after it is released with no further input, the state output is INIT (code 0), `evt_valid_o` is low, `busy_o` is low and `ep_cfg_allowed_o` is low.
- R2: In INIT a create pulse moves the state to ATTACHED (code 1) and emits event CREATE (code 1) on the next edge. In INIT every other input has no effect. Outside INIT a create pulse has no effect.
- R3: Conditions map to targets as follows: unplug gives ATTACHED, plug gives POWERED (2), bus reset gives DEFAULT (3), enumeration done gives ADDRESSED (4), set-configuration gives CONFIGURED (5). When several conditions arrive together, the priority is unplug, then plug, then bus reset, then set-configuration, then enumeration done.
- R4: Moving up, the state changes by exactly one level per clock. Each step emits one event: HUB_CFG (2) from ATTACHED, RESET (3) from POWERED, ADDR (4) from DEFAULT, CFG (5) from ADDRESSED.
- R5: Moving down, the state also changes by one level per clock. The events are DECFG (6) from CONFIGURED, RESET (3) from ADDRESSED, PWR_INT (7) from DEFAULT, HUB_RST (8) from POWERED.
- R6: A request for the current level emits no event and leaves the state unchanged.
- R7: `busy_o` is high while the state differs from the latched target and low once the target is reached.
- R8: A request that arrives during a walk replaces the target. The walk continues from the current level toward the new target.
- R9: `ep_cfg_allowed_o` is high only while the state is ADDRESSED or CONFIGURED.
- R10: Outside INIT, a suspend indication emits BUS_INACT (9) without changing the state. If a step is emitted in the same cycle, BUS_INACT is held back and emitted in the first cycle with no step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| create_i | input | 1 | Leaves INIT for ATTACHED |
| attach_i | input | 1 | Cable plugged into a powered bus |
| detach_i | input | 1 | Cable unplugged or bus unpowered |
| bus_reset_i | input | 1 | Bus reset seen |
| enum_done_i | input | 1 | Enumeration complete |
| set_cfg_i | input | 1 | Set-configuration received |
| suspend_i | input | 1 | Bus suspend seen |
| state_o | output | 3 | Current level code |
| busy_o | output | 1 | Walk in progress |
| evt_valid_o | output | 1 | Event strobe |
| evt_code_o | output | 4 | Event code |
| ep_cfg_allowed_o | output | 1 | Non-zero endpoint setup permitted |

## Verification
A corrupted level register shows up on `state_o` on the edge after the fault. It also shows up in the next event code, because that code is derived from the level a step starts from. A lost or stale target shows up as `busy_o` staying high, or as a walk that stops one rung short. The check is made one cycle after each step, so a skipped rung appears at most one sample later as a missing or out-of-order code. A dropped deferred suspend appears as a missing BUS_INACT in the first idle cycle after a walk.

// File: rtl/usb_dev_state_pkg.sv
// Shared level and event encodings for the enumeration state stepper.
// Assumes the level codes are ordered so that integer comparison gives ladder order.
package usb_dev_state_pkg;

    localparam int LVL_W = 3;
    localparam int EVT_W = 4;

    typedef enum logic [LVL_W-1:0] {
        LVL_INIT       = 3'd0,
        LVL_ATTACHED   = 3'd1,
        LVL_POWERED    = 3'd2,
        LVL_DEFAULT    = 3'd3,
        LVL_ADDRESSED  = 3'd4,
        LVL_CONFIGURED = 3'd5
    } lvl_t;

    typedef enum logic [EVT_W-1:0] {
        EV_NONE      = 4'd0,
        EV_CREATE    = 4'd1,
        EV_HUB_CFG   = 4'd2,
        EV_RESET     = 4'd3,
        EV_ADDR      = 4'd4,
        EV_CFG       = 4'd5,
        EV_DECFG     = 4'd6,
        EV_PWR_INT   = 4'd7,
        EV_HUB_RST   = 4'd8,
        EV_BUS_INACT = 4'd9
    } evt_t;

    // Event for one rung up, keyed by the starting level.
    function automatic evt_t up_event(lvl_t from);
        case (from)
            LVL_ATTACHED:  return EV_HUB_CFG;
            LVL_POWERED:   return EV_RESET;
            LVL_DEFAULT:   return EV_ADDR;
            LVL_ADDRESSED: return EV_CFG;
            default:       return EV_NONE;
        endcase
    endfunction

    // Event for one rung down, keyed by the starting level.
    function automatic evt_t down_event(lvl_t from);
        case (from)
            LVL_CONFIGURED: return EV_DECFG;
            LVL_ADDRESSED:  return EV_RESET;
            LVL_DEFAULT:    return EV_PWR_INT;
            LVL_POWERED:    return EV_HUB_RST;
            default:        return EV_NONE;
        endcase
    endfunction

endpackage

// File: rtl/usb_dev_req_decode.sv
// Turns the decoded bus-condition strobes into a single target-level request.
// Assumes the strobes are one cycle wide. Simultaneous strobes are resolved by fixed priority.
module usb_dev_req_decode
    import usb_dev_state_pkg::*;
(
    input  logic attach_i,
    input  logic detach_i,
    input  logic bus_reset_i,
    input  logic enum_done_i,
    input  logic set_cfg_i,
    output logic req_valid_o,
    output lvl_t req_lvl_o
);

    // Priority select: unplug, plug, bus reset, set-config, enumeration done.
    always_comb begin
        req_valid_o = 1'b1;
        if (detach_i)         req_lvl_o = LVL_ATTACHED;
        else if (attach_i)    req_lvl_o = LVL_POWERED;
        else if (bus_reset_i) req_lvl_o = LVL_DEFAULT;
        else if (set_cfg_i)   req_lvl_o = LVL_CONFIGURED;
        else if (enum_done_i) req_lvl_o = LVL_ADDRESSED;
        else begin
            req_valid_o = 1'b0;
            req_lvl_o   = LVL_INIT;
        end
    end

endmodule

// File: rtl/usb_dev_step_engine.sv
// Holds the current level and the latched target, and moves the level one rung per clock.
// Assumes requests are ignored in INIT and only a create pulse leaves INIT.
module usb_dev_step_engine
    import usb_dev_state_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic create_i,
    input  logic req_valid_i,
    input  lvl_t req_lvl_i,
    output lvl_t lvl_o,
    output logic busy_o,
    output logic step_up_o,
    output logic step_dn_o,
    output logic created_o
);

    lvl_t lvl_q, tgt_q, tgt_eff, lvl_d, tgt_d;
    logic seen_q;

    // Choose the effective target and the next level.
    always_comb begin
        step_up_o = 1'b0;
        step_dn_o = 1'b0;
        created_o = 1'b0;
        tgt_eff   = req_valid_i ? req_lvl_i : tgt_q;
        lvl_d     = lvl_q;
        tgt_d     = tgt_q;
        if (lvl_q == LVL_INIT) begin
            if (create_i) begin
                created_o = 1'b1;
                lvl_d     = LVL_ATTACHED;
                tgt_d     = LVL_ATTACHED;
            end
        end else begin
            tgt_d = tgt_eff;
            if (tgt_eff > lvl_q) begin
                step_up_o = 1'b1;
                lvl_d     = lvl_t'(lvl_q + 3'd1);
            end else if (tgt_eff < lvl_q) begin
                step_dn_o = 1'b1;
                lvl_d     = lvl_t'(lvl_q - 3'd1);
            end
        end
    end

    // Level and target registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q  <= LVL_INIT;
            tgt_q  <= LVL_INIT;
            seen_q <= 1'b0;
        end else begin
            lvl_q  <= lvl_d;
            tgt_q  <= tgt_d;
            seen_q <= 1'b1;
        end
    end

    assign lvl_o  = lvl_q;
    assign busy_o = (lvl_q != tgt_q);

    // R4
    step_one_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(lvl_q) != LVL_INIT) |->
        (lvl_q == $past(lvl_q) || lvl_q == lvl_t'($past(lvl_q) + 3'd1) ||
         lvl_q == lvl_t'($past(lvl_q) - 3'd1)));

    // R2
    init_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(lvl_q) == LVL_INIT && lvl_q != LVL_INIT) |->
        (lvl_q == LVL_ATTACHED && $past(create_i)));

    // R7
    idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !$past(busy_o) && !$past(req_valid_i) && !$past(create_i)) |->
        $stable(lvl_q));

endmodule

// File: rtl/usb_dev_event_gen.sv
// Registers one event code per clock from the step decisions. It defers a suspend event behind a step.
// Assumes at most one of step_up, step_dn and created is high in a cycle.
module usb_dev_event_gen
    import usb_dev_state_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  lvl_t lvl_i,
    input  logic step_up_i,
    input  logic step_dn_i,
    input  logic created_i,
    input  logic suspend_i,
    output logic evt_valid_o,
    output evt_t evt_code_o
);

    logic pend_q, pend_d, susp_want, valid_d;
    evt_t code_d;

    // Pick this cycle's event. A step wins over a suspend, which is kept pending.
    always_comb begin
        susp_want = pend_q | (suspend_i & (lvl_i != LVL_INIT));
        pend_d    = 1'b0;
        valid_d   = 1'b1;
        if (created_i) begin
            code_d = EV_CREATE;
            pend_d = susp_want;
        end else if (step_up_i) begin
            code_d = up_event(lvl_i);
            pend_d = susp_want;
        end else if (step_dn_i) begin
            code_d = down_event(lvl_i);
            pend_d = susp_want;
        end else if (susp_want) begin
            code_d = EV_BUS_INACT;
        end else begin
            code_d  = EV_NONE;
            valid_d = 1'b0;
        end
    end

    // Event output and pending-suspend registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_valid_o <= 1'b0;
            evt_code_o  <= EV_NONE;
            pend_q      <= 1'b0;
        end else begin
            evt_valid_o <= valid_d;
            evt_code_o  <= code_d;
            pend_q      <= pend_d;
        end
    end

    // R10
    no_empty_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid_o |-> (evt_code_o != EV_NONE));

endmodule

// File: rtl/usb_dev_state_stepper.sv
// Top of the enumeration state stepper: request decode, step engine, event generator.
// Assumes all condition inputs are synchronous single-cycle strobes.
module usb_dev_state_stepper
    import usb_dev_state_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             create_i,
    input  logic             attach_i,
    input  logic             detach_i,
    input  logic             bus_reset_i,
    input  logic             enum_done_i,
    input  logic             set_cfg_i,
    input  logic             suspend_i,
    output logic [LVL_W-1:0] state_o,
    output logic             busy_o,
    output logic             evt_valid_o,
    output logic [EVT_W-1:0] evt_code_o,
    output logic             ep_cfg_allowed_o
);

    logic req_valid, step_up, step_dn, created;
    lvl_t req_lvl, lvl;
    evt_t evt_code;
    logic seen_q;

    usb_dev_req_decode u_decode (
        .attach_i    (attach_i),
        .detach_i    (detach_i),
        .bus_reset_i (bus_reset_i),
        .enum_done_i (enum_done_i),
        .set_cfg_i   (set_cfg_i),
        .req_valid_o (req_valid),
        .req_lvl_o   (req_lvl)
    );

    usb_dev_step_engine u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .create_i    (create_i),
        .req_valid_i (req_valid),
        .req_lvl_i   (req_lvl),
        .lvl_o       (lvl),
        .busy_o      (busy_o),
        .step_up_o   (step_up),
        .step_dn_o   (step_dn),
        .created_o   (created)
    );

    usb_dev_event_gen u_events (
        .clk         (clk),
        .rst_n       (rst_n),
        .lvl_i       (lvl),
        .step_up_i   (step_up),
        .step_dn_i   (step_dn),
        .created_i   (created),
        .suspend_i   (suspend_i),
        .evt_valid_o (evt_valid_o),
        .evt_code_o  (evt_code)
    );

    assign state_o          = lvl;
    assign evt_code_o       = evt_code;
    assign ep_cfg_allowed_o = (lvl >= LVL_ADDRESSED);

    // Marks the first cycle after reset so that checks never look before it.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    // R4
    move_has_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && state_o != $past(state_o)) |-> evt_valid_o);

    // R9
    ep_cfg_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $rose(ep_cfg_allowed_o)) |-> (evt_code_o == EV_ADDR));

    // R5
    ep_cfg_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $fell(ep_cfg_allowed_o)) |-> (evt_code_o == EV_RESET));

endmodule

// File: tb/usb_dev_state_stepper_tb.sv
module usb_dev_state_stepper_tb;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic create_i = 0, attach_i = 0, detach_i = 0, bus_reset_i = 0;
    logic enum_done_i = 0, set_cfg_i = 0, suspend_i = 0;
    logic [2:0] state_o;
    logic busy_o, evt_valid_o, ep_cfg_allowed_o;
    logic [3:0] evt_code_o;
    int errors = 0, checks = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    usb_dev_state_stepper u_dut (
        .clk(clk), .rst_n(rst_n), .create_i(create_i), .attach_i(attach_i),
        .detach_i(detach_i), .bus_reset_i(bus_reset_i), .enum_done_i(enum_done_i),
        .set_cfg_i(set_cfg_i), .suspend_i(suspend_i), .state_o(state_o),
        .busy_o(busy_o), .evt_valid_o(evt_valid_o), .evt_code_o(evt_code_o),
        .ep_cfg_allowed_o(ep_cfg_allowed_o)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Check the state and event after an edge. Code -1 means no event is expected.
    task automatic expect_step(string req, int st, int code, int busy);
        chk({req, " state"}, state_o, st);
        if (code < 0) chk({req, " evt_valid"}, evt_valid_o, 0);
        else begin
            chk({req, " evt_valid"}, evt_valid_o, 1);
            chk({req, " evt_code"}, evt_code_o, code);
        end
        chk({req, " busy"}, busy_o, busy);
    endtask

    task automatic clear_inputs();
        create_i = 0; attach_i = 0; detach_i = 0; bus_reset_i = 0;
        enum_done_i = 0; set_cfg_i = 0; suspend_i = 0;
    endtask

    // R1: state and outputs during and after reset
    task automatic t_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        expect_step("R1", 0, -1, 0);
        chk("R1 ep_cfg", ep_cfg_allowed_o, 0);
    endtask

    // R2: requests ignored in INIT, create leaves INIT, a second create is ignored
    task automatic t_create();
        attach_i = 1; set_cfg_i = 1; suspend_i = 1;
        @(negedge clk); clear_inputs();
        expect_step("R2 init-ignore", 0, -1, 0);
        create_i = 1;
        @(negedge clk); clear_inputs();
        expect_step("R2 create", 1, 1, 0);
        create_i = 1;
        @(negedge clk); clear_inputs();
        expect_step("R2 create-again", 1, -1, 0);
    endtask

    // R3 R4 R9: plug, then set-config walks up through each rung
    task automatic t_walk_up();
        attach_i = 1;
        @(negedge clk); clear_inputs();
        expect_step("R3 plug", 2, 2, 0);
        set_cfg_i = 1;
        @(negedge clk); clear_inputs();
        expect_step("R4 up1", 3, 3, 1);
        chk("R9 below-addr", ep_cfg_allowed_o, 0);
        @(negedge clk);
        expect_step("R4 up2", 4, 4, 1);
        chk("R9 addressed", ep_cfg_allowed_o, 1);
        @(negedge clk);
        expect_step("R4 up3", 5, 5, 0);
        @(negedge clk);
        expect_step("R7 settled", 5, -1, 0);
    endtask

    // R6: same-level request gives no event
    task automatic t_same();
        set_cfg_i = 1;
        @(negedge clk); clear_inputs();
        expect_step("R6 same", 5, -1, 0);
    endtask

    // R10: idle suspend gives one bus-inactive event, level kept
    task automatic t_suspend_idle();
        suspend_i = 1;
        @(negedge clk); clear_inputs();
        expect_step("R10 idle", 5, 9, 0);
        @(negedge clk);
        expect_step("R10 once", 5, -1, 0);
    endtask

    // R5 R3 R9: unplug walks all the way down
    task automatic t_walk_down();
        detach_i = 1;
        @(negedge clk); clear_inputs();
        expect_step("R5 dn1", 4, 6, 1);
        @(negedge clk);
        expect_step("R5 dn2", 3, 3, 1);
        chk("R9 dropped", ep_cfg_allowed_o, 0);
        @(negedge clk);
        expect_step("R5 dn3", 2, 7, 1);
        @(negedge clk);
        expect_step("R5 dn4", 1, 8, 0);
    endtask

    // R8: retarget mid-walk, then R3 priority of unplug over plug
    task automatic t_retarget();
        set_cfg_i = 1;
        @(negedge clk); clear_inputs();
        expect_step("R8 first", 2, 2, 1);
        bus_reset_i = 1;
        @(negedge clk); clear_inputs();
        expect_step("R8 retarget", 3, 3, 0);
        @(negedge clk);
        expect_step("R8 stopped", 3, -1, 0);
        detach_i = 1; attach_i = 1;
        @(negedge clk); clear_inputs();
        expect_step("R3 prio1", 2, 7, 1);
        @(negedge clk);
        expect_step("R3 prio2", 1, 8, 0);
    endtask

    // R10: suspend during a walk is deferred until the walk ends
    task automatic t_suspend_walk();
        set_cfg_i = 1; suspend_i = 1;
        @(negedge clk); clear_inputs();
        expect_step("R10 w1", 2, 2, 1);
        @(negedge clk); expect_step("R10 w2", 3, 3, 1);
        @(negedge clk); expect_step("R10 w3", 4, 4, 1);
        @(negedge clk); expect_step("R10 w4", 5, 5, 0);
        @(negedge clk); expect_step("R10 deferred", 5, 9, 0);
        @(negedge clk); expect_step("R10 after", 5, -1, 0);
    endtask

    // R1: reset in the middle of operation returns to INIT
    task automatic t_reset_again();
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        expect_step("R1 again", 0, -1, 0);
        chk("R1 ep_cfg again", ep_cfg_allowed_o, 0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_create();
        t_walk_up();
        t_same();
        t_suspend_idle();
        t_walk_down();
        t_retarget();
        t_suspend_walk();
        t_reset_again();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule